// File: doc/BRIEF.md
# Periodic Trigger Cadence Veto

This block sits in a trigger path and watches single-cycle trigger pulses for a steady repetition rate. A fixed trigger rate can drive currents that excite mechanical resonance in fragile readout bonds. For every trigger the block measures the number of clock cycles since the previous accepted trigger and compares that gap with the gap measured before it. Gaps that agree within a programmable tolerance are counted, and once enough consecutive agreeing gaps are seen the block enters a veto state.

Two programmable bounds frame the measurement. A gap above the upper bound is treated as a slow, harmless trigger stream and clears all history. A gap below the lower bound marks a fast trigger that takes no part in the measurement at all. While vetoing, the block either removes triggers from its output (stand-alone operation) or leaves them untouched and raises a busy flag so that the trigger source holds back (run operation), which keeps event numbering intact. A saturating counter accumulates the cycles spent in the veto state.

Top module: `trig_resonance_guard`

## Requirements
- R1: After reset `trig_out`, `busy_out` and `veto_active` are 0 and `veto_cycles` is 0.
- R2: The gap of a trigger is the number of rising clock edges from the previous accepted trigger to this one; the first trigger after reset, or after a gap above `period_max`, only starts a measurement, so with `match_limit` = L a constant gap vetoes on the (L+2)-th trigger and not before.
- R3: A trigger whose gap lies inside the window and differs from the stored reference gap by at most `match_tol` increments the match count; a difference of `match_tol`+1 sets the count to 0. In both cases the gap becomes the new reference.
- R4: `veto_active` rises on the clock edge that samples the trigger whose match brings the count to `match_limit`.
- R5: A gap strictly above `period_max` clears the match count and the reference; a gap equal to `period_max` is inside the window.
- R6: A trigger whose gap is below `period_min` is ignored by the measurement: it does not restart the gap count, change the match count or replace the reference. A gap equal to `period_min` is inside the window.
- R7: With `mode_standalone` = 1, `trig_out` is 0 whenever the veto is active and `busy_out` stays 0.
- R8: With `mode_standalone` = 0, `trig_out` follows `trig_in` in the same cycle and `busy_out` equals the veto state.
- R9: While vetoing, an in-window trigger that does not match releases the veto on the edge that samples it; that trigger is still removed in stand-alone mode.
- R10: When no accepted trigger arrives, the veto releases on the edge at which the gap count has exceeded `period_max`, i.e. `period_max`+1 edges after the last accepted trigger.
- R11: `veto_cycles` adds one for every clock edge sampled while the veto is active, holds at its all-ones value, and is set to 0 on the edge that samples `stat_clear` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Incoming single-cycle trigger pulse |
| mode_standalone | input | 1 | 1: veto removes triggers; 0: veto raises busy |
| match_tol | input | PW (16) | Largest gap difference still counted as a match |
| period_min | input | PW (16) | Smallest gap taking part in the measurement |
| period_max | input | PW (16) | Largest gap taking part in the measurement |
| match_limit | input | MW (8) | Match count at which the veto starts |
| stat_clear | input | 1 | Synchronous clear of the veto-time counter |
| trig_out | output | 1 | Trigger after veto gating |
| busy_out | output | 1 | Busy request during veto in run mode |
| veto_active | output | 1 | Veto state |
| veto_cycles | output | SW (32) | Saturating count of cycles spent vetoing |

## Verification
The hardest state to reach from the ports is a match count that has been built up around ignored fast triggers: the stimulus interleaves a pulse five cycles after each slow trigger and shows that the veto still starts on exactly the fourth slow period, which only happens if the fast pulses neither restart the gap count nor disturb the reference. The tolerance edge is reached by alternating gaps one count inside and one count outside the tolerance, and the window edges by constant streams at exactly the minimum, exactly the maximum and one cycle above it. The timeout release is probed on the edge before and the edge of expiry, and counter saturation is reached through a second instance with a four-bit veto-time counter.

// File: rtl/trg_pkg.sv
`timescale 1ns/1ps
package trg_pkg;
    // Position of a measured gap relative to the programmed window
    typedef enum logic [1:0] {
        GAP_SHORT  = 2'd0,
        GAP_WINDOW = 2'd1,
        GAP_LONG   = 2'd2
    } gap_class_e;
endpackage

// File: rtl/trg_gap_meter.sv
`timescale 1ns/1ps
module trg_gap_meter #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    output logic [PW-1:0] gap_o
);
    localparam logic [PW-1:0] GAP_TOP = '1;
    localparam logic [PW-1:0] GAP_ONE = {{(PW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [PW-1:0] gap;
    } meter_st_t;

    meter_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.gap = GAP_ONE;
        end else if (st_q.gap != GAP_TOP) begin
            st_d.gap = st_q.gap + GAP_ONE;
        end
    end

    // Reset to the top value: the first trigger sees an over-long gap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{gap: GAP_TOP};
        else        st_q <= st_d;
    end

    assign gap_o = st_q.gap;

    assert_gap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gap == GAP_TOP && !restart_i) |=> (st_q.gap == GAP_TOP));

    assert_gap_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (st_q.gap == GAP_ONE));
endmodule

// File: rtl/trg_cadence_tracker.sv
`timescale 1ns/1ps
module trg_cadence_tracker
    import trg_pkg::*;
#(
    parameter int PW = 16,
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_i,
    input  logic [PW-1:0] gap_i,
    input  logic [PW-1:0] tol_i,
    input  logic [PW-1:0] min_i,
    input  logic [PW-1:0] max_i,
    input  logic [MW-1:0] limit_i,
    output logic          accept_o,
    output logic          veto_o
);
    localparam logic [MW-1:0] HITS_TOP = '1;
    localparam logic [MW-1:0] HITS_ONE = {{(MW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [PW-1:0] ref_gap;
        logic          ref_ok;
        logic [MW-1:0] hits;
        logic          veto;
    } track_st_t;

    track_st_t     st_d, st_q;
    gap_class_e    cls;
    logic [PW-1:0] delta;
    logic          near;
    logic [MW-1:0] hits_bump;

    always_comb begin
        if (gap_i > max_i)      cls = GAP_LONG;
        else if (gap_i < min_i) cls = GAP_SHORT;
        else                    cls = GAP_WINDOW;

        delta     = (gap_i >= st_q.ref_gap) ? (gap_i - st_q.ref_gap)
                                            : (st_q.ref_gap - gap_i);
        near      = st_q.ref_ok && (delta <= tol_i);
        hits_bump = (st_q.hits == HITS_TOP) ? st_q.hits : (st_q.hits + HITS_ONE);
        accept_o  = trig_i && (cls != GAP_SHORT);

        st_d = st_q;
        if (cls == GAP_LONG) begin
            // Slow stream or idle timeout: forget all history
            st_d.ref_ok = 1'b0;
            st_d.hits   = '0;
            st_d.veto   = 1'b0;
        end else if (trig_i && cls == GAP_WINDOW) begin
            st_d.ref_gap = gap_i;
            st_d.ref_ok  = 1'b1;
            if (near) begin
                st_d.hits = hits_bump;
                if (hits_bump >= limit_i) st_d.veto = 1'b1;
            end else begin
                st_d.hits = '0;
                st_d.veto = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign veto_o = st_q.veto;

    assert_veto_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.veto) |-> $past(trig_i && near && cls == GAP_WINDOW));

    // Covers R10 as well: release needs a mismatch or an expired gap
    assert_veto_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.veto) |-> $past(cls == GAP_LONG || (trig_i && !near)));

    assert_short_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && cls == GAP_SHORT) |=> ($stable(st_q.hits) && $stable(st_q.ref_gap)));

    assert_long_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == GAP_LONG) |=> (st_q.hits == '0 && !st_q.veto && !st_q.ref_ok));
endmodule

// File: rtl/trg_veto_stat.sv
`timescale 1ns/1ps
module trg_veto_stat #(
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          veto_i,
    input  logic          clear_i,
    output logic [SW-1:0] cycles_o
);
    localparam logic [SW-1:0] CYC_TOP = '1;
    localparam logic [SW-1:0] CYC_ONE = {{(SW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [SW-1:0] cycles;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cycles = '0;
        end else if (veto_i && st_q.cycles != CYC_TOP) begin
            st_d.cycles = st_q.cycles + CYC_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cycles_o = st_q.cycles;

    assert_stat_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && veto_i && st_q.cycles != CYC_TOP) |=> (st_q.cycles == $past(st_q.cycles) + CYC_ONE));

    assert_stat_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.cycles == '0));

    assert_stat_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !veto_i) |=> $stable(st_q.cycles));
endmodule

// File: rtl/trig_resonance_guard.sv
`timescale 1ns/1ps
module trig_resonance_guard #(
    parameter int PW = 16,
    parameter int MW = 8,
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_in,
    input  logic          mode_standalone,
    input  logic [PW-1:0] match_tol,
    input  logic [PW-1:0] period_min,
    input  logic [PW-1:0] period_max,
    input  logic [MW-1:0] match_limit,
    input  logic          stat_clear,
    output logic          trig_out,
    output logic          busy_out,
    output logic          veto_active,
    output logic [SW-1:0] veto_cycles
);
    logic [PW-1:0] gap;
    logic          accept;
    logic          veto;

    trg_gap_meter #(.PW(PW)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (accept),
        .gap_o     (gap)
    );

    trg_cadence_tracker #(.PW(PW), .MW(MW)) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig_in),
        .gap_i    (gap),
        .tol_i    (match_tol),
        .min_i    (period_min),
        .max_i    (period_max),
        .limit_i  (match_limit),
        .accept_o (accept),
        .veto_o   (veto)
    );

    trg_veto_stat #(.SW(SW)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .veto_i   (veto),
        .clear_i  (stat_clear),
        .cycles_o (veto_cycles)
    );

    always_comb begin
        trig_out    = trig_in && !(mode_standalone && veto);
        busy_out    = !mode_standalone && veto;
        veto_active = veto;
    end

    assert_standalone_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_standalone && veto) |-> (!trig_out && !busy_out));

    assert_run_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_standalone && trig_in) |-> trig_out);
endmodule

// File: tb/test_trig_resonance_guard.sv
`timescale 1ns/1ps
module test_trig_resonance_guard;
    localparam int PW = 16;
    localparam int MW = 8;
    localparam int SW = 32;
    localparam int MAXP = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_in = 1'b0;
    logic          mode_standalone = 1'b0;
    logic [PW-1:0] match_tol = 16'd2;
    logic [PW-1:0] period_min = 16'd10;
    logic [PW-1:0] period_max = 16'(MAXP);
    logic [MW-1:0] match_limit = 8'd3;
    logic          stat_clear = 1'b0;
    logic          trig_out, busy_out, veto_active;
    logic [SW-1:0] veto_cycles;
    logic          n_trig_out, n_busy_out, n_veto_active;
    logic [3:0]    n_veto_cycles;

    int checks = 0;
    int errors = 0;
    logic pass_seen, busy_seen, veto_after;
    logic [31:0] exp_cyc = 0;
    logic [3:0]  exp_cyc_n = 0;

    always #2.5 clk = ~clk;

    trig_resonance_guard #(.PW(PW), .MW(MW), .SW(SW)) i_trig_resonance_guard (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .mode_standalone(mode_standalone),
        .match_tol(match_tol), .period_min(period_min), .period_max(period_max),
        .match_limit(match_limit), .stat_clear(stat_clear), .trig_out(trig_out),
        .busy_out(busy_out), .veto_active(veto_active), .veto_cycles(veto_cycles));

    trig_resonance_guard #(.PW(PW), .MW(MW), .SW(4)) i_trig_resonance_guard_narrow (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .mode_standalone(mode_standalone),
        .match_tol(match_tol), .period_min(period_min), .period_max(period_max),
        .match_limit(match_limit), .stat_clear(stat_clear), .trig_out(n_trig_out),
        .busy_out(n_busy_out), .veto_active(n_veto_active), .veto_cycles(n_veto_cycles));

    // Expected veto time: a veto seen at a falling edge is counted at the next rising edge
    always @(negedge clk) begin
        if (!rst_n || stat_clear) begin
            exp_cyc   <= 0;
            exp_cyc_n <= 0;
        end else if (veto_active) begin
            exp_cyc   <= exp_cyc + 1;
            exp_cyc_n <= (exp_cyc_n == 4'hF) ? exp_cyc_n : exp_cyc_n + 4'd1;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One trigger, then wait so that the next trigger is sampled gap edges later
    task automatic send_trig(input int gap);
        trig_in = 1'b1;
        @(negedge clk);
        pass_seen = trig_out;
        busy_seen = busy_out;
        tick();
        trig_in = 1'b0;
        veto_after = veto_active;
        for (int i = 0; i < gap - 1; i++) tick();
    endtask

    task automatic idle_clear();
        for (int i = 0; i < MAXP + 5; i++) tick();
    endtask

    task automatic test_reset();
        chk("R1", "trig_out", trig_out, 0);
        chk("R1", "busy_out", busy_out, 0);
        chk("R1", "veto_active", veto_active, 0);
        chk("R1", "veto_cycles", veto_cycles, 0);
    endtask

    task automatic test_run_mode();
        mode_standalone = 1'b0;
        idle_clear();
        for (int k = 0; k < 4; k++) send_trig(20);
        chk("R2", "veto after four triggers", veto_after, 0);
        send_trig(20);
        chk("R4", "veto after fifth trigger", veto_after, 1);
        chk("R8", "busy while vetoing", busy_out, 1);
        send_trig(20);
        chk("R8", "trigger passes in run mode", pass_seen, 1);
        chk("R8", "busy seen with trigger", busy_seen, 1);
        // 19 edges already elapsed since the last trigger
        for (int i = 0; i < 81; i++) tick();
        chk("R10", "veto one edge before expiry", veto_active, 1);
        tick();
        chk("R10", "veto released at expiry", veto_active, 0);
        chk("R8", "busy released", busy_out, 0);
        chk("R11", "veto time count", veto_cycles, exp_cyc);
        chk("R11", "narrow counter saturates", n_veto_cycles, exp_cyc_n);
        chk("R11", "narrow counter at top", n_veto_cycles, 15);
        stat_clear = 1'b1;
        tick();
        stat_clear = 1'b0;
        chk("R11", "clear empties counter", veto_cycles, 0);
        chk("R11", "clear empties narrow counter", n_veto_cycles, 0);
    endtask

    task automatic test_standalone();
        mode_standalone = 1'b1;
        idle_clear();
        for (int k = 0; k < 5; k++) send_trig(20);
        chk("R4", "standalone veto set", veto_after, 1);
        chk("R7", "no busy in standalone", busy_out, 0);
        send_trig(25);
        chk("R7", "trigger removed", pass_seen, 0);
        chk("R7", "busy low with removed trigger", busy_seen, 0);
        send_trig(20);
        chk("R9", "mismatching trigger still removed", pass_seen, 0);
        chk("R9", "mismatch releases veto", veto_after, 0);
        send_trig(20);
        chk("R7", "trigger passes after release", pass_seen, 1);
        chk("R3", "two mismatches keep veto low", veto_after, 0);
        chk("R11", "standalone veto time", veto_cycles, exp_cyc);
        mode_standalone = 1'b0;
    endtask

    task automatic test_tolerance();
        idle_clear();
        send_trig(20); send_trig(22); send_trig(20);
        send_trig(22);
        chk("R3", "difference of tol matches, no veto yet", veto_after, 0);
        send_trig(20);
        chk("R3", "difference of tol reaches limit", veto_after, 1);
        idle_clear();
        send_trig(20); send_trig(20); send_trig(23); send_trig(20); send_trig(20);
        send_trig(20);
        chk("R3", "difference tol+1 resets count", veto_after, 0);
        send_trig(20);
        chk("R3", "count rebuilding", veto_after, 0);
        send_trig(20);
        chk("R3", "veto after rebuilt count", veto_after, 1);
    endtask

    task automatic test_min_window();
        idle_clear();
        send_trig(40);
        for (int k = 1; k <= 4; k++) begin
            send_trig(5);
            if (k == 3) chk("R6", "veto not yet with fast pulses", veto_after, 0);
            if (k == 4) chk("R6", "veto on fourth slow trigger", veto_after, 1);
            send_trig(35);
            if (k == 1) chk("R8", "fast pulse passes in run mode", pass_seen, 1);
        end
        idle_clear();
        for (int k = 0; k < 4; k++) send_trig(10);
        chk("R6", "gap equal to min, not yet", veto_after, 0);
        send_trig(10);
        chk("R6", "gap equal to min is in window", veto_after, 1);
    endtask

    task automatic test_max_window();
        idle_clear();
        for (int k = 0; k < 6; k++) send_trig(MAXP + 1);
        chk("R5", "gap above max never vetoes", veto_after, 0);
        idle_clear();
        for (int k = 0; k < 4; k++) send_trig(MAXP);
        chk("R5", "gap equal to max, not yet", veto_after, 0);
        send_trig(MAXP);
        chk("R5", "gap equal to max is in window", veto_after, 1);
        idle_clear();
        chk("R10", "idle clears veto", veto_active, 0);
        chk("R11", "final veto time", veto_cycles, exp_cyc);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        test_reset();
        rst_n = 1'b1;
        tick();
        test_reset();
        test_run_mode();
        test_standalone();
        test_tolerance();
        test_min_window();
        test_max_window();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule